// File: doc/BRIEF.md
# Synchronous USB FIFO Bridge Controller

This block sits between on-chip logic and an external USB FIFO device that runs in its synchronous FIFO mode and supplies the clock. Bytes the device has received from the host are pulled across the 8-bit device bus and handed to internal logic on a valid/ready receive stream. Bytes offered on a valid/ready transmit stream are pushed across the same bus into the device. All logic runs on the device's output clock.

The engine is half duplex. It never reads and writes in the same cycle. A pending receive wins over a pending transmit. Each read asserts output enable one cycle before the read strobe. The shared bus is driven only during a write cycle, and an idle cycle always separates a read from a write.

The bidirectional data bus is presented as separate input, output and drive-enable signals, so the pad buffer can live in the chip's I/O ring.

Top module: `usbf_bridge`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, the following hold: `oe_n_o`, `rd_n_o` and `wr_n_o` are high, `bus_drive_o` is low, `rx_valid_o` is low and `tx_ready_o` is low.
- R2: A read runs in three steps.
  - From idle, with `rxf_n_i` low and no byte held, the clock edge sets `oe_n_o` low with `rd_n_o` high.
  - On the next edge, if `rxf_n_i` is still low, `rd_n_o` also goes low.
  - On the edge that ends the strobe cycle, the byte on `bus_in_i` is captured. `rx_valid_o` rises together with the strobes returning high.
- R3: A byte is captured only while both `rxf_n_i` and `rd_n_o` are low. If `rxf_n_i` is high during the enable or strobe cycle, the strobes return high at the next edge and no byte is delivered.
- R4: A captured byte stays on `rx_data_o` with `rx_valid_o` high and unchanged until a cycle with `rx_ready_i` high. No new read starts while a byte is held.
- R5: A write runs as follows.
  - From idle, with `rxf_n_i` high, `txe_n_i` low and `tx_valid_i` high, the next edge sets `wr_n_o` low and `bus_drive_o` high, with `tx_data_i` on `bus_out_o`.
  - In that write cycle `tx_ready_o` equals the inverse of `txe_n_i`.
  - The write cycle lasts one cycle, then the bus returns to idle.
- R6: No write starts while `txe_n_i` is high. If `txe_n_i` is high during the write cycle, `tx_ready_o` stays low and the byte stays pending for a later attempt.
- R7: `wr_n_o` is never low in the same cycle as `oe_n_o` or `rd_n_o`. While `rxf_n_i` is low, no write starts from idle.
- R8: There is at least one cycle between a read and a write, in either order, in which the bus is not driven and all three strobes are high.
- R9: `bus_drive_o` is high only in a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock from the FIFO device |
| rst_i | input | 1 | Synchronous active-high reset |
| rxf_n_i | input | 1 | Device has a received byte (active low) |
| txe_n_i | input | 1 | Device can accept a byte (active low) |
| bus_in_i | input | DATA_W | Data read from the device bus |
| bus_out_o | output | DATA_W | Data to drive onto the device bus |
| bus_drive_o | output | 1 | Drive enable for the bus pads |
| oe_n_o | output | 1 | Output enable to the device (active low) |
| rd_n_o | output | 1 | Read strobe (active low) |
| wr_n_o | output | 1 | Write strobe (active low) |
| rx_data_o | output | DATA_W | Received byte |
| rx_valid_o | output | 1 | Received byte is valid |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| tx_data_i | input | DATA_W | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte is offered |
| tx_ready_o | output | 1 | Transmit byte is taken this cycle |

## Verification
Strobes, drive enable and `bus_out_o` change one edge after the idle decision that starts an access. `rx_valid_o` rises on the third edge after `rxf_n_i` falls from idle. `tx_ready_o` is combinational on the write state and `txe_n_i`, so it is valid within the write cycle itself. The bench drives each row of inputs just after the falling clock edge and samples all outputs two time units later, before the next rising edge. Each expected row therefore describes the state left by all earlier edges plus the current flag inputs.

// File: rtl/usbf_pkg.sv
package usbf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_OE  = 2'd1,
    ST_RD_ACT = 2'd2,
    ST_WR     = 2'd3
  } usbf_state_e;
endpackage

// File: rtl/usbf_seq.sv
module usbf_seq
  import usbf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic rxf_n_i,
  input  logic txe_n_i,
  input  logic rx_full_i,
  input  logic tx_valid_i,
  output logic capture_o,
  output logic wr_load_o,
  output logic wr_done_o,
  output logic oe_n_o,
  output logic rd_n_o,
  output logic wr_n_o,
  output logic drive_o
);
  usbf_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (!rxf_n_i && !rx_full_i)            state_d = ST_RD_OE;
        else if (rxf_n_i && !txe_n_i && tx_valid_i) state_d = ST_WR;
      end
      ST_RD_OE:  state_d = rxf_n_i ? ST_IDLE : ST_RD_ACT;
      ST_RD_ACT: state_d = ST_IDLE;
      ST_WR:     state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign capture_o = (state_q == ST_RD_ACT) && !rxf_n_i;
  assign wr_done_o = (state_q == ST_WR) && !txe_n_i;
  assign wr_load_o = (state_q == ST_IDLE) && (state_d == ST_WR);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      oe_n_o  <= 1'b1;
      rd_n_o  <= 1'b1;
      wr_n_o  <= 1'b1;
      drive_o <= 1'b0;
    end else begin
      state_q <= state_d;
      oe_n_o  <= !((state_d == ST_RD_OE) || (state_d == ST_RD_ACT));
      rd_n_o  <= !(state_d == ST_RD_ACT);
      wr_n_o  <= !(state_d == ST_WR);
      drive_o <= (state_d == ST_WR);
    end
  end

  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !(!wr_n_o && (!rd_n_o || !oe_n_o)));
  p_oe_first_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rd_n_o) |-> $past(!oe_n_o));
  p_rd_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(oe_n_o) |-> $past(!rxf_n_i));
  p_wr_txe_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(wr_n_o) |-> $past(!txe_n_i));
  p_rd_prio_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(wr_n_o) |-> $past(rxf_n_i));
  p_turn_rw_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(drive_o) |-> $past(oe_n_o));
  p_turn_wr_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(oe_n_o) |-> $past(!drive_o));
  p_drive_wr_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    drive_o |-> !wr_n_o);
endmodule

// File: rtl/usbf_rx_hold.sv
module usbf_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (capture_i) begin
      valid_o <= 1'b1;
      data_o  <= din_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/usbf_tx_launch.sv
module usbf_tx_launch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] bus_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)       bus_o <= '0;
    else if (load_i) bus_o <= din_i;
  end

  p_launch_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (bus_o == $past(din_i)));
endmodule

// File: rtl/usbf_bridge.sv
module usbf_bridge #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rxf_n_i,
  input  logic              txe_n_i,
  input  logic [DATA_W-1:0] bus_in_i,
  output logic [DATA_W-1:0] bus_out_o,
  output logic              bus_drive_o,
  output logic              oe_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  logic capture, wr_load, wr_done;

  usbf_seq u_seq (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .rxf_n_i    (rxf_n_i),
    .txe_n_i    (txe_n_i),
    .rx_full_i  (rx_valid_o),
    .tx_valid_i (tx_valid_i),
    .capture_o  (capture),
    .wr_load_o  (wr_load),
    .wr_done_o  (wr_done),
    .oe_n_o     (oe_n_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o),
    .drive_o    (bus_drive_o)
  );

  usbf_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .capture_i (capture),
    .din_i     (bus_in_i),
    .ready_i   (rx_ready_i),
    .valid_o   (rx_valid_o),
    .data_o    (rx_data_o)
  );

  usbf_tx_launch #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (wr_load),
    .din_i  (tx_data_i),
    .bus_o  (bus_out_o)
  );

  assign tx_ready_o = wr_done;

  p_cap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rx_valid_o) |-> ($past(!rd_n_o) && $past(!rxf_n_i)));
  p_txr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_ready_o |-> (!wr_n_o && bus_drive_o));
endmodule

// File: tb/usbf_bridge_bench.sv
module usbf_bridge_bench;
  localparam int W = 8;
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxf_n = 1'b1, txe_n = 1'b1, rx_ready = 1'b0, tx_valid = 1'b0;
  logic [W-1:0] bus_in = '0, tx_data = '0;
  logic [W-1:0] bus_out, rx_data;
  logic bus_drive, oe_n, rd_n, wr_n, rx_valid, tx_ready;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usbf_bridge #(.DATA_W(W)) u_usbf_bridge (
    .clk_i(clk), .rst_i(rst), .rxf_n_i(rxf_n), .txe_n_i(txe_n),
    .bus_in_i(bus_in), .bus_out_o(bus_out), .bus_drive_o(bus_drive),
    .oe_n_o(oe_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready)
  );

  // row: req[37:34] rxf txe txv txd din rxr | oe rd wr drv rxv txr | data
  localparam logic [37:0] VEC [NV] = '{
    {4'd1, 3'b110, 8'h00, 8'h00, 1'b0, 6'b111000, 8'h00}, // R1 idle
    {4'd2, 3'b010, 8'h00, 8'h00, 1'b0, 6'b111000, 8'h00}, // R2 flag falls
    {4'd2, 3'b010, 8'h00, 8'hA5, 1'b0, 6'b011000, 8'h00}, // R2 enable first
    {4'd2, 3'b010, 8'h00, 8'hA5, 1'b0, 6'b001000, 8'h00}, // R2 strobe
    {4'd4, 3'b010, 8'h00, 8'h00, 1'b0, 6'b111010, 8'hA5}, // R4 held
    {4'd4, 3'b010, 8'h00, 8'h00, 1'b0, 6'b111010, 8'hA5}, // R4 no new read
    {4'd4, 3'b010, 8'h00, 8'h00, 1'b1, 6'b111010, 8'hA5}, // R4 consumed
    {4'd4, 3'b010, 8'h00, 8'h3C, 1'b0, 6'b111000, 8'h00}, // R4 empty
    {4'd2, 3'b010, 8'h00, 8'h3C, 1'b0, 6'b011000, 8'h00}, // R2 second read
    {4'd3, 3'b110, 8'h00, 8'h3C, 1'b0, 6'b001000, 8'h00}, // R3 flag rises
    {4'd3, 3'b110, 8'h00, 8'h00, 1'b0, 6'b111000, 8'h00}, // R3 no byte
    {4'd5, 3'b101, 8'h5A, 8'h00, 1'b0, 6'b111000, 8'h00}, // R5 offer
    {4'd5, 3'b101, 8'h5A, 8'h00, 1'b0, 6'b110101, 8'h5A}, // R5 write
    {4'd5, 3'b101, 8'hC3, 8'h00, 1'b0, 6'b111000, 8'h00}, // R5 back idle
    {4'd6, 3'b111, 8'hC3, 8'h00, 1'b0, 6'b110100, 8'hC3}, // R6 txe rises
    {4'd6, 3'b111, 8'hC3, 8'h00, 1'b0, 6'b111000, 8'h00}, // R6 blocked
    {4'd6, 3'b111, 8'hC3, 8'h00, 1'b0, 6'b111000, 8'h00}, // R6 blocked
    {4'd7, 3'b001, 8'hC3, 8'h00, 1'b0, 6'b111000, 8'h00}, // R7 both pending
    {4'd7, 3'b001, 8'hC3, 8'h77, 1'b0, 6'b011000, 8'h00}, // R7 read wins
    {4'd7, 3'b001, 8'hC3, 8'h77, 1'b0, 6'b001000, 8'h00}, // R7 strobe
    {4'd8, 3'b101, 8'hC3, 8'h00, 1'b1, 6'b111010, 8'h77}, // R8 gap after read
    {4'd9, 3'b101, 8'hC3, 8'h00, 1'b0, 6'b110101, 8'hC3}, // R9 retried write
    {4'd8, 3'b000, 8'h00, 8'h00, 1'b0, 6'b111000, 8'h00}, // R8 gap after write
    {4'd8, 3'b010, 8'h00, 8'h11, 1'b0, 6'b011000, 8'h00}, // R8 read starts
    {4'd2, 3'b010, 8'h00, 8'h11, 1'b0, 6'b001000, 8'h00}, // R2 strobe
    {4'd4, 3'b110, 8'h00, 8'h00, 1'b1, 6'b111010, 8'h11}, // R4 taken
    {4'd4, 3'b110, 8'h00, 8'h00, 1'b0, 6'b111000, 8'h00}  // R4 empty
  };

  function automatic logic [13:0] observe();
    logic [7:0] d;
    d = bus_drive ? bus_out : (rx_valid ? rx_data : 8'h00);
    return {oe_n, rd_n, wr_n, bus_drive, rx_valid, tx_ready, d};
  endfunction

  task automatic check(input int req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #2 check(1, observe(), {6'b111000, 8'h00}); // R1 during reset
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2 check(1, observe(), {6'b111000, 8'h00}); // R1 after release

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rxf_n    = VEC[i][33];
      txe_n    = VEC[i][32];
      tx_valid = VEC[i][31];
      tx_data  = VEC[i][30:23];
      bus_in   = VEC[i][22:15];
      rx_ready = VEC[i][14];
      #2 check(int'(VEC[i][37:34]), observe(), VEC[i][13:0]);
    end

    // R1: reset in the middle of a read strobe
    @(negedge clk);
    rxf_n = 1'b0; txe_n = 1'b1; tx_valid = 1'b0; rx_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #2 check(2, observe(), {6'b001000, 8'h00}); // R2 strobe reached
    rst = 1'b1;
    @(negedge clk);
    #2 check(1, observe(), {6'b111000, 8'h00}); // R1 mid-read reset
    rxf_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2 check(1, observe(), {6'b111000, 8'h00}); // R1 no stale byte

    // R6: txe high for many cycles, no write ever starts
    txe_n = 1'b1; tx_valid = 1'b1; tx_data = 8'h99;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #2 check(6, observe(), {6'b111000, 8'h00}); // R6 held off
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule